// File: doc/BRIEF.md
# Selectable-Length Pseudo-Random Bit Stream Generator

This block emits a serial test stream of one bit per clock, with a valid flag, taken from a maximal-length linear feedback shift register. Software-free static inputs choose the register length from seven options, a mark-ratio setting that thins or thickens the density of ones, and a whole-stream inversion. Two complete settings (A and B) are presented at the inputs, and an alternate control picks one of them. An external gate can stop the stream, and three error-injection modes flip single output bits for receiver testing.

Mark ratio below one half is made by ANDing the new sequence bit with the one or two bits emitted just before it. The upper four mark codes are the bitwise complement of the lower four. The register is loaded with all ones at reset and whenever the effective length changes, so it cannot reach the all-zero state.

Top module: `prbs_pattern_gen`

## Requirements
- R1: Length code 0..6 selects N = 7, 9, 10, 11, 15, 23, 31 (code 7 also selects 31); with mark code 0, no inversion and no errors, the valid stream repeats every 2^N-1 bits and one period holds 2^(N-1) ones.
- R2: Each new sequence bit is the XOR of the bits emitted N and M positions earlier, with (N,M) = (7,6), (9,5), (10,7), (11,9), (15,14), (23,18), (31,28); the register starts from all ones and never holds all zeros.
- R3: Mark code 0 gives the raw bit b, code 1 gives b AND the previous bit, code 2 gives b AND the two previous bits, code 3 gives constant 0.
- R4: Mark codes 4, 5, 6, 7 give the complement of codes 0, 1, 2, 3; code 7 without inversion or error yields constant 1 on every valid bit.
- R5: The invert input of the active setting complements every valid output bit.
- R6: With alt_en low setting A is used; with alt_en high, alt_sel high selects A and alt_sel low selects B.
- R7: When the effective length differs from the one last used, the register is reloaded with all ones and that cycle's output is invalid (dvalid 0, dout 0); the sequence then restarts from the seed.
- R8: When gate is low the next output has dvalid 0 and dout 0 and the sequence does not advance.
- R9: err_mode 1 flips every 10^K-th valid bit, K = 4 + err_rate for err_rate 0..5 and K = 9 for 6 and 7; the count restarts whenever the mode is left.
- R10: err_mode 2 flips exactly one valid bit per rising edge of err_cmd, the first valid bit at or after that edge.
- R11: err_mode 3 flips exactly one valid bit per falling edge of err_ext, seen through a two-stage synchroniser, on the next valid bit.
- R12: Outputs are registered: inputs sampled at a clock edge show on dout/dvalid right after that edge; during reset dvalid and dout are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_a_len | input | 3 | Setting A length code |
| cfg_a_mark | input | 3 | Setting A mark-ratio code |
| cfg_a_inv | input | 1 | Setting A output inversion |
| cfg_b_len | input | 3 | Setting B length code |
| cfg_b_mark | input | 3 | Setting B mark-ratio code |
| cfg_b_inv | input | 1 | Setting B output inversion |
| alt_en | input | 1 | Enables A/B selection by alt_sel |
| alt_sel | input | 1 | High picks A, low picks B when alt_en is high |
| gate | input | 1 | Low inhibits the output and holds the sequence |
| err_mode | input | 2 | 0 off, 1 rate, 2 command, 3 external |
| err_rate | input | 3 | Rate exponent code for err_mode 1 |
| err_cmd | input | 1 | Single-error command, rising edge acts |
| err_ext | input | 1 | Asynchronous external error input, falling edge acts |
| dout | output | 1 | Serial data bit |
| dvalid | output | 1 | dout carries a sequence bit |

## Verification
The assertions assume the configuration inputs change only between clock edges and that err_cmd is synchronous to clk, while err_ext may move at any time. The forced-level checks rely on the alternate control staying off and the error mode staying zero for the cycle they observe, and the bench holds those inputs steady in the directed phases. Random phases move settings, gate and error inputs only at the falling clock edge, and the repeat-rate phase keeps the length fixed so no reload splits its count.

// File: rtl/prbs_pattern_gen.sv
module prbs_pattern_gen #(
  parameter int CW = 30
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cfg_a_len,
  input  logic [2:0] cfg_a_mark,
  input  logic       cfg_a_inv,
  input  logic [2:0] cfg_b_len,
  input  logic [2:0] cfg_b_mark,
  input  logic       cfg_b_inv,
  input  logic       alt_en,
  input  logic       alt_sel,
  input  logic       gate,
  input  logic [1:0] err_mode,
  input  logic [2:0] err_rate,
  input  logic       err_cmd,
  input  logic       err_ext,
  output logic       dout,
  output logic       dvalid
);
  localparam int SW = 31;

  logic [SW-1:0] lfsr;
  logic [2:0]    len_q;
  logic [CW-1:0] cnt, lim;
  logic          ext_s1, ext_s2, ext_d, cmd_d, pend;
  logic          fb, base;

  wire       use_b = alt_en & ~alt_sel;
  wire [2:0] len   = use_b ? cfg_b_len  : cfg_a_len;
  wire [2:0] mark  = use_b ? cfg_b_mark : cfg_a_mark;
  wire       inv   = use_b ? cfg_b_inv  : cfg_a_inv;

  wire reseed = (len != len_q);
  wire valid  = gate & ~reseed;
  wire ev     = ((err_mode == 2'd2) & err_cmd & ~cmd_d) |
                ((err_mode == 2'd3) & ext_d & ~ext_s2);
  wire rep    = (err_mode == 2'd1) & (cnt == lim - 1'b1);
  wire flip   = (err_mode[1] & (pend | ev)) | rep;

  always_comb begin
    case (len)
      3'd0:    fb = lfsr[6]  ^ lfsr[5];
      3'd1:    fb = lfsr[8]  ^ lfsr[4];
      3'd2:    fb = lfsr[9]  ^ lfsr[6];
      3'd3:    fb = lfsr[10] ^ lfsr[8];
      3'd4:    fb = lfsr[14] ^ lfsr[13];
      3'd5:    fb = lfsr[22] ^ lfsr[17];
      default: fb = lfsr[30] ^ lfsr[27];
    endcase
  end

  always_comb begin
    case (mark[1:0])
      2'd0:    base = fb;
      2'd1:    base = fb & lfsr[0];
      2'd2:    base = fb & lfsr[0] & lfsr[1];
      default: base = 1'b0;
    endcase
  end

  always_comb begin
    case (err_rate)
      3'd0:    lim = CW'(10000);
      3'd1:    lim = CW'(100000);
      3'd2:    lim = CW'(1000000);
      3'd3:    lim = CW'(10000000);
      3'd4:    lim = CW'(100000000);
      default: lim = CW'(1000000000);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr   <= '1;
      len_q  <= '0;
      cnt    <= '0;
      pend   <= 1'b0;
      ext_s1 <= 1'b0;
      ext_s2 <= 1'b0;
      ext_d  <= 1'b0;
      cmd_d  <= 1'b0;
      dout   <= 1'b0;
      dvalid <= 1'b0;
    end else begin
      ext_s1 <= err_ext;
      ext_s2 <= ext_s1;
      ext_d  <= ext_s2;
      cmd_d  <= err_cmd;
      len_q  <= len;
      if (reseed)    lfsr <= '1;
      else if (gate) lfsr <= {lfsr[SW-2:0], fb};
      dvalid <= valid;
      dout   <= valid & (base ^ mark[2] ^ inv ^ flip);
      pend   <= err_mode[1] ? ((pend | ev) & ~valid) : 1'b0;
      if (err_mode != 2'd1) cnt <= '0;
      else if (valid)       cnt <= (cnt == lim - 1'b1) ? '0 : cnt + 1'b1;
    end
  end
endmodule

module prbs_pattern_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        gate,
  input logic        alt_en,
  input logic [2:0]  cfg_a_mark,
  input logic        cfg_a_inv,
  input logic [1:0]  err_mode,
  input logic [30:0] lfsr,
  input logic        dout,
  input logic        dvalid
);
  assert_gate_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> (!dvalid && !dout));

  assert_valid_follows_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dvalid |-> $past(gate));

  assert_zero_mark_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!alt_en && cfg_a_mark == 3'd3 && !cfg_a_inv && err_mode == 2'd0) |=> !dout);

  assert_full_mark_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!alt_en && cfg_a_mark == 3'd7 && !cfg_a_inv && err_mode == 2'd0) |=> (dout || !dvalid));

  assert_lfsr_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr != '0);
endmodule

bind prbs_pattern_gen prbs_pattern_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .gate(gate), .alt_en(alt_en),
  .cfg_a_mark(cfg_a_mark), .cfg_a_inv(cfg_a_inv), .err_mode(err_mode),
  .lfsr(lfsr), .dout(dout), .dvalid(dvalid)
);

// File: tb/prbs_pattern_gen_tb.sv
module prbs_pattern_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] cfg_a_len = 0, cfg_a_mark = 0, cfg_b_len = 0, cfg_b_mark = 0;
  logic cfg_a_inv = 0, cfg_b_inv = 0, alt_en = 0, alt_sel = 1, gate = 0;
  logic [1:0] err_mode = 0;
  logic [2:0] err_rate = 0;
  logic err_cmd = 0, err_ext = 0;
  logic dout, dvalid;

  always #2 clk = ~clk;

  prbs_pattern_gen u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_a_len(cfg_a_len), .cfg_a_mark(cfg_a_mark), .cfg_a_inv(cfg_a_inv),
    .cfg_b_len(cfg_b_len), .cfg_b_mark(cfg_b_mark), .cfg_b_inv(cfg_b_inv),
    .alt_en(alt_en), .alt_sel(alt_sel), .gate(gate),
    .err_mode(err_mode), .err_rate(err_rate), .err_cmd(err_cmd), .err_ext(err_ext),
    .dout(dout), .dvalid(dvalid)
  );

  int total = 0, bad = 0;
  string cur_req = "R12";

  // reference model state
  bit [30:0] h;
  int lq, cnt, flips, ncap, ones;
  bit e1, e2, ed, cd, pd, exp_d, exp_v, exp_c, capturing;
  bit cap [0:1199];
  int NT [0:7] = '{7, 9, 10, 11, 15, 23, 31, 31};
  int MT [0:7] = '{6, 5, 7, 9, 14, 18, 28, 28};

  function automatic int lim_of(int r);
    int v = 10000;
    int k = (r > 5) ? 5 : r;
    for (int i = 0; i < k; i++) v = v * 10;
    return v;
  endfunction

  task automatic chk(bit ok, string r, int act, int expv, string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", r, what, act, expv);
    end
  endtask

  task automatic model_reset();
    h = '1; lq = 0; cnt = 0; e1 = 0; e2 = 0; ed = 0; cd = 0; pd = 0;
    exp_d = 0; exp_v = 0; exp_c = 0;
  endtask

  task automatic model_step();
    bit ub, iv, ev, b, bs, fl, vld, clean;
    int l, mk;
    ub = alt_en & ~alt_sel;
    l  = int'(ub ? cfg_b_len : cfg_a_len);
    mk = int'(ub ? cfg_b_mark : cfg_a_mark);
    iv = ub ? cfg_b_inv : cfg_a_inv;
    ev = (err_mode == 2 && err_cmd && !cd) || (err_mode == 3 && ed && !e2);
    vld = 0;
    if (l != lq) begin
      h = '1; lq = l; exp_v = 0; exp_d = 0; exp_c = 0;
    end else if (gate) begin
      vld = 1;
      b = h[NT[l]-1] ^ h[MT[l]-1];
      case (mk % 4)
        0: bs = b;
        1: bs = b & h[0];
        2: bs = b & h[0] & h[1];
        default: bs = 0;
      endcase
      clean = bs ^ (mk >= 4) ^ iv;
      fl = (err_mode >= 2 && (pd || ev)) || (err_mode == 1 && cnt == lim_of(int'(err_rate)) - 1);
      exp_c = clean; exp_d = clean ^ fl; exp_v = 1;
      h = {h[29:0], b};
    end else begin
      exp_v = 0; exp_d = 0; exp_c = 0;
    end
    pd = (err_mode >= 2) ? ((pd || ev) && !vld) : 0;
    if (err_mode != 1) cnt = 0;
    else if (vld) cnt = (cnt == lim_of(int'(err_rate)) - 1) ? 0 : cnt + 1;
    ed = e2; e2 = e1; e1 = err_ext; cd = err_cmd;
  endtask

  task automatic step();
    model_step();
    @(negedge clk);
    chk(dvalid === exp_v, cur_req, dvalid, exp_v, "dvalid");
    chk(dout === exp_d, cur_req, dout, exp_d, "dout");
    if (dvalid && dout !== exp_c) flips++;
    if (capturing && dvalid && ncap < 1200) begin cap[ncap] = dout; ncap++; end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic period_test(int code, string r);
    int p;
    cfg_a_len = 3'(code); cfg_a_mark = 0; cfg_a_inv = 0; alt_en = 0; gate = 1; err_mode = 0;
    step();
    ncap = 0; capturing = 1;
    p = (1 << NT[code]) - 1;
    run(p + 160);
    capturing = 0;
    ones = 0;
    for (int i = 0; i < p; i++) ones += cap[i];
    chk(ones == (1 << (NT[code] - 1)), r, ones, 1 << (NT[code] - 1), "ones per period");
    begin
      int mism = 0;
      for (int i = 0; i < 150; i++) if (cap[i] != cap[i + p]) mism++;
      chk(mism == 0, r, mism, 0, "period repeat");
    end
  endtask

  task automatic count_ones(int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin step(); if (dvalid && dout) c++; end
  endtask

  initial begin
    #(4ns * 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c;
    void'($urandom(32'd4242));
    model_reset();
    // R12: reset state
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(dvalid === 1'b0 && dout === 1'b0, "R12", {dvalid, dout}, 0, "reset outputs");
    end
    rst_n = 1;

    cur_req = "R1";
    period_test(0, "R1");
    cur_req = "R2";
    period_test(1, "R2");
    period_test(2, "R1");

    // R3/R4/R5 mark ratio
    cfg_a_len = 4; cfg_a_mark = 0; step();
    cur_req = "R3";
    cfg_a_mark = 1; count_ones(2000, c);
    chk(c > 380 && c < 620, "R3", c, 500, "quarter density");
    cfg_a_mark = 3; count_ones(200, c);
    chk(c == 0, "R3", c, 0, "zero mark");
    cur_req = "R4";
    cfg_a_mark = 7; count_ones(200, c);
    chk(c == 200, "R4", c, 200, "full mark");
    cfg_a_mark = 6; count_ones(2000, c);
    chk(c > 1650 && c < 1850, "R4", c, 1750, "seven-eighths density");
    cur_req = "R5";
    cfg_a_mark = 3; cfg_a_inv = 1; count_ones(100, c);
    chk(c == 100, "R5", c, 100, "inverted zero mark");
    cfg_a_inv = 0;

    // R6 alternate selection
    cur_req = "R6";
    cfg_b_len = 4; cfg_b_mark = 7; cfg_b_inv = 0; alt_en = 1; alt_sel = 1;
    count_ones(50, c);
    chk(c == 0, "R6", c, 0, "alt high picks A");
    alt_sel = 0; count_ones(50, c);
    chk(c == 50, "R6", c, 50, "alt low picks B");
    alt_en = 0; count_ones(50, c);
    chk(c == 0, "R6", c, 0, "alt disabled picks A");

    // R7 reseed
    cur_req = "R7";
    cfg_a_mark = 0; cfg_a_len = 0; step();
    chk(dvalid === 1'b0, "R7", dvalid, 0, "reload cycle invalid");
    run(30);

    // R8 gate
    cur_req = "R8";
    gate = 0; count_ones(20, c);
    chk(dvalid === 1'b0, "R8", dvalid, 0, "gated valid");
    gate = 1; run(20);

    // R10 single command
    cur_req = "R10";
    cfg_a_len = 3; step(); run(5);
    err_mode = 2; flips = 0;
    for (int k = 0; k < 3; k++) begin
      err_cmd = 1; step(); step(); err_cmd = 0; run(10);
    end
    gate = 0; err_cmd = 1; step(); err_cmd = 0; run(3); gate = 1; run(5);
    chk(flips == 4, "R10", flips, 4, "command flips");

    // R11 external
    cur_req = "R11";
    err_mode = 3; flips = 0;
    for (int k = 0; k < 4; k++) begin
      err_ext = 1; run(5); err_ext = 0; run(5);
    end
    run(5);
    chk(flips == 4, "R11", flips, 4, "external flips");

    // R9 rate errors
    cur_req = "R9";
    err_mode = 0; step();
    err_mode = 1; err_rate = 0; flips = 0;
    run(20005);
    chk(flips == 2, "R9", flips, 2, "rate flips");
    err_mode = 0; run(5);

    // random mix
    cur_req = "R6,R7,R8,R10,R11";
    for (int i = 0; i < 3000; i++) begin
      if (i % 40 == 0) begin
        cfg_a_len = 3'($urandom % 8); cfg_a_mark = 3'($urandom % 8); cfg_a_inv = 1'($urandom % 2);
        cfg_b_len = 3'($urandom % 8); cfg_b_mark = 3'($urandom % 8); cfg_b_inv = 1'($urandom % 2);
        alt_en = 1'($urandom % 2);
        err_mode = 2'($urandom % 4); err_rate = 0;
      end
      if (i % 10 == 0) alt_sel = 1'($urandom % 2);
      gate = ($urandom % 5) != 0;
      err_cmd = ($urandom % 7) == 0;
      if ($urandom % 4 == 0) err_ext = ~err_ext;
      step();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule